// File: doc/BRIEF.md
# Power-Domain State Control Register

This block is the control and status word for one power domain. Software writes a requested power state through a single-word read/write port. The block reports the state the domain has actually reached. That reported state follows the request after a fixed, parameterised settling time. The same word also carries:
- two sticky history bits, one recording that the domain was power-gated and one recording that it was clock-gated;
- a device-disable control;
- a reset control.

From the reached state the block drives the domain's power-enable, clock-enable and isolation outputs. The reset and device-disable controls go straight to their own outputs.

State codes are four bits wide. Code 0xF means fully active. Code 0x0 means power-gated. Any code from 0x1 to 0xE counts as clock-gated: the domain is powered but its clock is stopped. A domain built with the always-on option leaves reset already in the active state.

Top module: `pdc_ctl`

## Requirements
- R1: Bits 3:0 of the word hold the requested state; a write stores wr_data[3:0] there, and it reads back.
- R2: Bits 7:4 report the reached state; a write never changes this field.
- R3: When a write changes the requested state, the reached state takes the new value exactly SETTLE clock edges after the write edge and holds its old value until then. A write that changes the request again before that restarts the count. A write that leaves the request unchanged does not restart it.
- R4: pwr_en and clk_en are high only while the reached state is 0xF. iso_en is high whenever the reached state is not 0xF.
- R5: Bit 8 sets on the edge where the reached state changes to 0x0.
- R6: Bit 9 sets on the edge where the reached state changes to a code in 0x1..0xE.
- R7: Bits 8 and 9 are cleared by writing 1 to them, and writing 0 leaves them unchanged. When a clear and a set fall on the same edge, the set wins.
- R8: Bit 10 holds the written value and drives dev_dis. Bit 31 holds the written value and drives rst_out.
- R9: Bits 30:11 ignore writes and always read as zero.
- R10: After reset, bits 8, 9, 10 and 31 are zero. The requested and reached states are both 0x0, or both 0xF when ALWAYS_ON is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current value of the control word |
| pwr_en | output | 1 | Domain power enable |
| clk_en | output | 1 | Domain clock enable |
| iso_en | output | 1 | Domain output isolation |
| dev_dis | output | 1 | Device disable |
| rst_out | output | 1 | Domain reset |

## Verification
Two events can land on the same clock edge: a hardware set of a history bit, because the reached state enters a gated code, and a software write-1 clear of that bit. The bench makes them collide by issuing a request write and then, exactly SETTLE edges later, a write that clears the clock-gated bit while leaving the request unchanged. It then checks that the bit reads back as set. Related checks confirm that the non-restarting write did not delay the settle, and that a lone clear afterwards does remove the bit.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int WORD_W = 32;
  localparam int PS_W   = 4;

  typedef logic [PS_W-1:0] pstate_t;

  localparam pstate_t PS_ACTIVE = 4'hF;
  localparam pstate_t PS_OFF    = 4'h0;

  localparam int B_PGATED = 8;
  localparam int B_CGATED = 9;
  localparam int B_DIS    = 10;
  localparam int B_RST    = 31;

  function automatic logic is_off(input pstate_t s);
    return s == PS_OFF;
  endfunction

  function automatic logic is_clk_stopped(input pstate_t s);
    return (s != PS_OFF) && (s != PS_ACTIVE);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
    input logic    rst_b,
    input logic    dis_b,
    input logic    cg_b,
    input logic    pg_b,
    input pstate_t act,
    input pstate_t tgt);
    logic [WORD_W-1:0] w;
    w            = '0;
    w[3:0]       = tgt;
    w[7:4]       = act;
    w[B_PGATED]  = pg_b;
    w[B_CGATED]  = cg_b;
    w[B_DIS]     = dis_b;
    w[B_RST]     = rst_b;
    return w;
  endfunction
endpackage

// File: rtl/pdc_settle.sv
module pdc_settle
  import pdc_pkg::*;
#(
  parameter int SETTLE    = 8,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_wr,
  input  pstate_t req_new,
  output pstate_t tgt_q,
  output pstate_t act_q,
  output logic    done
);
  localparam int      CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);
  localparam pstate_t RST_PS = ALWAYS_ON ? PS_ACTIVE : PS_OFF;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             req_chg;

  assign req_chg = req_wr && (req_new != tgt_q);
  assign done    = busy_q && (cnt_q == '0) && !req_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= RST_PS;
      act_q  <= RST_PS;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (req_chg) begin
      tgt_q  <= req_new;
      cnt_q  <= CNT_W'(SETTLE - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        act_q  <= tgt_q;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdc_hist.sv
module pdc_hist #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_ev,
  input  logic [NFLAG-1:0] clr_ev,
  output logic [NFLAG-1:0] flag_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (set_ev[i]) flag_q[i] <= 1'b1;
      else if (clr_ev[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pdc_ctl.sv
module pdc_ctl
  import pdc_pkg::*;
#(
  parameter int SETTLE    = 8,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              pwr_en,
  output logic              clk_en,
  output logic              iso_en,
  output logic              dev_dis,
  output logic              rst_out
);
  pstate_t    tgt_st;
  pstate_t    act_st;
  logic       settle_done;
  logic       pg_enter;
  logic       cg_enter;
  logic [1:0] hist_q;
  logic       dis_q;
  logic       rst_q;

  pdc_settle #(.SETTLE(SETTLE), .ALWAYS_ON(ALWAYS_ON)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_wr  (wr_en),
    .req_new (wr_data[3:0]),
    .tgt_q   (tgt_st),
    .act_q   (act_st),
    .done    (settle_done)
  );

  assign pg_enter = settle_done && is_off(tgt_st) && (act_st != tgt_st);
  assign cg_enter = settle_done && is_clk_stopped(tgt_st) && (act_st != tgt_st);

  pdc_hist #(.NFLAG(2)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev ({cg_enter, pg_enter}),
    .clr_ev ({wr_en && wr_data[B_CGATED], wr_en && wr_data[B_PGATED]}),
    .flag_q (hist_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (wr_en) begin
      dis_q <= wr_data[B_DIS];
      rst_q <= wr_data[B_RST];
    end
  end

  assign rd_data = pack_word(rst_q, dis_q, hist_q[1], hist_q[0], act_st, tgt_st);
  assign pwr_en  = (act_st == PS_ACTIVE);
  assign clk_en  = (act_st == PS_ACTIVE);
  assign iso_en  = (act_st != PS_ACTIVE);
  assign dev_dis = dis_q;
  assign rst_out = rst_q;
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk
  import pdc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              pwr_en,
  input logic              clk_en,
  input logic              iso_en,
  input logic              settle_done
);
  p_actual_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:4] != $past(rd_data[7:4])) |-> $past(settle_done));

  p_actual_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !settle_done |=> $stable(rd_data[7:4]));

  p_pwr_only_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en || clk_en) |-> (rd_data[7:4] == PS_ACTIVE));

  p_iso_not_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:4] != PS_ACTIVE) |-> iso_en);

  p_pg_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_done && rd_data[3:0] == PS_OFF && rd_data[7:4] != PS_OFF)
      |=> rd_data[B_PGATED]);

  p_cg_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_done && is_clk_stopped(rd_data[3:0]) && rd_data[7:4] != rd_data[3:0])
      |=> rd_data[B_CGATED]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_CGATED] && !(wr_en && wr_data[B_CGATED])) |=> rd_data[B_CGATED]);

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[30:11] == '0);
endmodule

bind pdc_ctl pdc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .pwr_en      (pwr_en),
  .clk_en      (clk_en),
  .iso_en      (iso_en),
  .settle_done (settle_done)
);

// File: tb/tb_pdc_ctl.sv
module tb_pdc_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int NVEC       = 6;

  // {write data, expected word once settled}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_000F, 32'h0000_00FF},
    {32'h0000_0005, 32'h0000_0255},
    {32'h0000_0200, 32'h0000_0100},
    {32'h8000_040F, 32'h8000_05FF},
    {32'hFFFF_FFFF, 32'h8000_04FF},
    {32'h0000_00A3, 32'h0000_0233}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_ao;
  logic        pwr_en, clk_en, iso_en, dev_dis, rst_out;
  logic        pwr_ao, clk_ao, iso_ao, dis_ao, rst_ao;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdc_ctl #(.SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_en(pwr_en), .clk_en(clk_en), .iso_en(iso_en),
    .dev_dis(dev_dis), .rst_out(rst_out)
  );

  pdc_ctl #(.SETTLE(SETTLE), .ALWAYS_ON(1'b1)) dut_ao (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_data(32'h0),
    .rd_data(rd_ao), .pwr_en(pwr_ao), .clk_en(clk_ao), .iso_en(iso_ao),
    .dev_dis(dis_ao), .rst_out(rst_ao)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R4 outputs when power-gated
    chk("R10 reset word", rd_data, 32'h0);
    chk("R4 reset enables/iso", {29'd0, pwr_en, clk_en, iso_en}, 32'h1);
    chk("R8 reset controls", {30'd0, dev_dis, rst_out}, 32'h0);
    chk("R10 always-on reset word", rd_ao, 32'h0000_00FF);
    chk("R4 always-on enables", {29'd0, pwr_ao, clk_ao, iso_ao}, 32'h6);

    // R1 R2 R5 R6 R7 R8 R9: vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      e = VEC[v][31:0];
      wr(VEC[v][63:32]);
      idle(SETTLE);
      chk($sformatf("R1/R2/R9 vector %0d", v), rd_data, e);
      chk($sformatf("R4 vector %0d", v), {29'd0, pwr_en, clk_en, iso_en},
          (e[7:4] == 4'hF) ? 32'h6 : 32'h1);
      chk($sformatf("R8 vector %0d", v), {30'd0, dev_dis, rst_out}, {30'd0, e[10], e[31]});
    end

    // R3 exact latency: reached state is 3, request 0xC
    wr(32'h0000_000C);
    idle(SETTLE - 1);
    chk("R3 holds before settle", {28'd0, rd_data[7:4]}, 32'h3);
    idle(1);
    chk("R3 updates at settle", {28'd0, rd_data[7:4]}, 32'hC);

    // R3 retarget restarts, R5 power-gated flag
    wr(32'h0000_000F);
    idle(2);
    wr(32'h0000_0000);
    idle(SETTLE - 1);
    chk("R3 restart holds old", {28'd0, rd_data[7:4]}, 32'hC);
    idle(1);
    chk("R5 reached off, flag set", rd_data, 32'h0000_0300);

    // R7 set beats clear on same edge; R3 same-request write no restart
    wr(32'h0000_0307);
    chk("R7 clear both flags", rd_data, 32'h0000_0007);
    idle(SETTLE - 1);
    chk("R3 not yet reached", {28'd0, rd_data[7:4]}, 32'h0);
    wr(32'h0000_0207);
    chk("R7 set wins over clear, R6", rd_data, 32'h0000_0277);
    chk("R4 clock-gated outputs", {29'd0, pwr_en, clk_en, iso_en}, 32'h1);

    // R7 write of 0 leaves flag; lone clear removes it
    wr(32'h0000_0007);
    idle(SETTLE);
    chk("R7 zero write keeps flag", rd_data, 32'h0000_0277);
    wr(32'h0000_0207);
    chk("R7 lone clear", rd_data, 32'h0000_0077);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule